// File: doc/BRIEF.md
# Handshaked Parallel Peripheral Port

This block connects a simple CPU register bus to an 8-bit peripheral data bus. Software configures the direction of the peripheral lines through a control register. It then moves bytes through a data register and polls a status register to learn when the port can take another byte and when a received byte is waiting.

In output mode, a CPU write to the data register drives the byte onto the peripheral lines and raises a data-offered line. The peripheral takes the byte and raises its acknowledge line. The port drops the data-offered line, and the transfer closes only when the peripheral drops its acknowledge. A write that arrives before the transfer has closed is discarded and recorded in a sticky error flag.

In input mode, a rising edge on the peripheral's strobe latches the peripheral lines into the receive register and marks the byte as valid. Both the acknowledge and the strobe cross into the port's clock domain through flop synchronizers before any logic uses them.

Top module: `hsk_port`

## Requirements
- R1: After reset, the status register (offset 2) reads 0x01, which is idle/ready set, no received byte and no error. The control register (offset 1) reads 0x00, which is input mode. `dataAvail` is 0 and `extDataOe` is 0x00.
- R2: Bit 0 of the control register at offset 1 selects the direction: 1 is output and 0 is input. It reads back unchanged. Every bit of `extDataOe` equals that bit.
- R3: In output mode with ready set (status bit 0), a write to the data register at offset 0 places the byte on `extDataOut` and raises `dataAvail` after the next clock edge. From then on, status bit 0 reads 0, and `dataAvail` and ready are never both 1.
- R4: `dataAvail` stays high until `dataAccepted` has been high for the synchroniser delay. It falls no earlier than three clock edges and no later than four clock edges after `dataAccepted` rises.
- R5: Ready returns to 1 only after `dataAccepted` has been seen low again following the fall of `dataAvail`. Until then, no new transfer can start.
- R6: In output mode, a data write while ready is 0 leaves `extDataOut` unchanged and sets the sticky error bit (status bit 2). That bit stays set until a write to offset 2 with bit 2 set to 1.
- R7: In input mode, a rising edge of `inStrobe` latches `extDataIn` and sets status bit 1 within four clock edges. A read of offset 0 returns the latched byte.
- R8: A CPU read of offset 0 clears status bit 1.
- R9: In input mode, a write to offset 0 has no effect: `dataAvail` stays 0, ready stays 1 and the error bit stays 0.
- R10: In output mode, `inStrobe` edges have no effect: status bit 1 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | CPU bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset: 0 data, 1 control, 2 status |
| busWdata | input | 8 | CPU write data |
| busRdata | output | 8 | CPU read data (combinational from offset) |
| extDataOut | output | 8 | Byte driven toward the peripheral |
| extDataOe | output | 8 | Per-line output enable |
| extDataIn | input | 8 | Byte from the peripheral |
| dataAvail | output | 1 | Port offers a byte (handshake request) |
| dataAccepted | input | 1 | Peripheral acknowledge (asynchronous) |
| inStrobe | input | 1 | Peripheral input strobe (asynchronous) |

## Verification
The checker watches, on every cycle, the properties that can be tested at any moment: the offer line and ready are never both high, ready rises only while the offer line is low, the offer falls only after the synchronised acknowledge, the enables are uniform, a busy write sets the error flag, the error flag clears only on an explicit clear write, and the receive flag rises only in input mode. Only the bench scenarios can show the end-to-end effects on the data path. These include the exact byte that reaches the peripheral, that a busy write leaves the output byte intact, what a read returns, that a read clears the receive flag, and that writes in input mode and strobes in output mode have no visible effect.

// File: rtl/hskp_pkg.sv
package hskp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd2;

  localparam int unsigned BIT_DIR   = 0;
  localparam int unsigned BIT_READY = 0;
  localparam int unsigned BIT_RXV   = 1;
  localparam int unsigned BIT_OVR   = 2;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_OFFER   = 2'd1,
    TX_RELEASE = 2'd2
  } txState_t;

  typedef struct packed {
    logic loadTx;
    logic loadDir;
    logic captureRx;
    logic clearRx;
    logic setOvr;
    logic clearOvr;
  } dpStrobe_t;
endpackage

// File: rtl/hskp_sync.sv
module hskp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hskp_ctrl.sv
module hskp_ctrl
  import hskp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              clrOvrBit,
  input  logic              dirOut,
  input  logic              dataAccepted,
  input  logic              inStrobe,
  output dpStrobe_t         strobes,
  output logic              dataAvail,
  output logic              ready
);
  txState_t state, stateNext;
  logic ackSync, stbSync, stbPrev;
  logic wrData, rdData, wrCtrl, wrStat;

  hskp_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(clk), .rstN(rstN), .asyncIn(dataAccepted), .syncOut(ackSync)
  );
  hskp_sync #(.STAGES(SYNC_STAGES)) u_stbSync (
    .clk(clk), .rstN(rstN), .asyncIn(inStrobe), .syncOut(stbSync)
  );

  always_comb begin
    wrData = busSel &&  busWr && (busAddr == OFS_DATA);
    rdData = busSel && !busWr && (busAddr == OFS_DATA);
    wrCtrl = busSel &&  busWr && (busAddr == OFS_CTRL);
    wrStat = busSel &&  busWr && (busAddr == OFS_STAT);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      TX_IDLE:    if (wrData && dirOut) stateNext = TX_OFFER;
      TX_OFFER:   if (ackSync)          stateNext = TX_RELEASE;
      TX_RELEASE: if (!ackSync)         stateNext = TX_IDLE;
      default:                          stateNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      stbPrev <= 1'b0;
    end else begin
      state   <= stateNext;
      stbPrev <= stbSync;
    end
  end

  assign ready     = (state == TX_IDLE);
  assign dataAvail = (state == TX_OFFER);

  always_comb begin
    strobes.loadTx    = wrData && dirOut && ready;
    strobes.setOvr    = wrData && dirOut && !ready;
    strobes.loadDir   = wrCtrl;
    strobes.clearOvr  = wrStat && clrOvrBit;
    strobes.captureRx = stbSync && !stbPrev && !dirOut;
    strobes.clearRx   = rdData;
  end
endmodule

// File: rtl/hskp_datapath.sv
module hskp_datapath
  import hskp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic              ready,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] extDataOut,
  output logic [DATA_W-1:0] extDataOe,
  output logic              dirOut,
  output logic              rxValid,
  output logic              ovrFlag
);
  logic [DATA_W-1:0] txReg, rxReg;
  logic [DATA_W-1:0] statusWord, ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      rxReg   <= '0;
      dirOut  <= 1'b0;
      rxValid <= 1'b0;
      ovrFlag <= 1'b0;
    end else begin
      if (strobes.loadTx)    txReg  <= busWdata;
      if (strobes.loadDir)   dirOut <= busWdata[BIT_DIR];
      if (strobes.captureRx) rxReg  <= extDataIn;
      if (strobes.captureRx)    rxValid <= 1'b1;
      else if (strobes.clearRx) rxValid <= 1'b0;
      if (strobes.setOvr)        ovrFlag <= 1'b1;
      else if (strobes.clearOvr) ovrFlag <= 1'b0;
    end
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_oe
      assign extDataOe[b] = dirOut;
    end
  endgenerate

  assign extDataOut = txReg;

  always_comb begin
    statusWord            = '0;
    statusWord[BIT_READY] = ready;
    statusWord[BIT_RXV]   = rxValid;
    statusWord[BIT_OVR]   = ovrFlag;
    ctrlWord              = '0;
    ctrlWord[BIT_DIR]     = dirOut;
    unique case (busAddr)
      OFS_DATA: busRdata = rxReg;
      OFS_CTRL: busRdata = ctrlWord;
      OFS_STAT: busRdata = statusWord;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/hsk_port.sv
module hsk_port
  import hskp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] extDataOut,
  output logic [DATA_W-1:0] extDataOe,
  input  logic [DATA_W-1:0] extDataIn,
  output logic              dataAvail,
  input  logic              dataAccepted,
  input  logic              inStrobe
);
  dpStrobe_t strobes;
  logic readyFlag, dirFlag, rxFlag, ovrFlag;

  hskp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .clrOvrBit(busWdata[BIT_OVR]),
    .dirOut(dirFlag),
    .dataAccepted(dataAccepted), .inStrobe(inStrobe),
    .strobes(strobes), .dataAvail(dataAvail), .ready(readyFlag)
  );

  hskp_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .ready(readyFlag),
    .busAddr(busAddr), .busWdata(busWdata), .extDataIn(extDataIn),
    .busRdata(busRdata), .extDataOut(extDataOut), .extDataOe(extDataOe),
    .dirOut(dirFlag), .rxValid(rxFlag), .ovrFlag(ovrFlag)
  );
endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] extDataOe,
  input logic       dataAvail,
  input logic       dataAccepted,
  input logic       readyFlag,
  input logic       dirFlag,
  input logic       rxFlag,
  input logic       ovrFlag
);
  assert_offer_not_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(dataAvail && readyFlag));

  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataAvail) |-> $past(dataAccepted, SYNC_STAGES + 1));

  assert_ready_after_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> (!dataAvail && $past(!dataAvail)));

  assert_oe_uniform_R2: assert property (@(posedge clk) disable iff (!rstN)
    (extDataOe != 8'h00) |-> (extDataOe == 8'hFF));

  assert_busy_write_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd0 && dirFlag && !readyFlag) |=> ovrFlag);

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrFlag) |-> $past(busSel && busWr && busAddr == 2'd2 && busWdata[2]));

  assert_rx_input_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> !$past(dirFlag));
endmodule

bind hsk_port hsk_port_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .extDataOe(extDataOe), .dataAvail(dataAvail),
  .dataAccepted(dataAccepted), .readyFlag(readyFlag), .dirFlag(dirFlag),
  .rxFlag(rxFlag), .ovrFlag(ovrFlag)
);

// File: tb/tb_hsk_port.sv
module tb_hsk_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata, extDataOut, extDataOe, extDataIn = '0;
  logic       dataAvail, dataAccepted = 1'b0, inStrobe = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hsk_port dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extDataOut(extDataOut),
    .extDataOe(extDataOe), .extDataIn(extDataIn), .dataAvail(dataAvail),
    .dataAccepted(dataAccepted), .inStrobe(inStrobe)
  );

  function automatic logic [7:0] expStatus(bit rdy, bit rxv, bit ovr);
    return {5'b0, ovr, rxv, rdy};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStrobe();
    @(negedge clk); inStrobe = 1'b1;
    idle(3);
    inStrobe = 1'b0;
    idle(4);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rd;
    logic [7:0] byteVal;
    void'($urandom(32'd1357));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    busRead(2'd2, rd); check("R1 status", rd, expStatus(1, 0, 0));
    busRead(2'd1, rd); check("R1 ctrl", rd, 8'h00);
    check("R1 dataAvail", dataAvail, 0);
    check("R1 oe", extDataOe, 8'h00);

    // R9 write in input mode does nothing
    busWrite(2'd0, 8'h5A);
    idle(2);
    check("R9 dataAvail", dataAvail, 0);
    busRead(2'd2, rd); check("R9 status", rd, expStatus(1, 0, 0));

    // R2 direction select
    busWrite(2'd1, 8'h01);
    check("R2 oe out", extDataOe, 8'hFF);
    busRead(2'd1, rd); check("R2 ctrl readback", rd, 8'h01);

    // R10 strobe ignored in output mode
    extDataIn = 8'hC3;
    pulseStrobe();
    busRead(2'd2, rd); check("R10 status", rd, expStatus(1, 0, 0));

    // R3..R6 random output transfers
    for (int i = 0; i < 12; i++) begin
      bit busyWrite;
      byteVal = 8'($urandom());
      busyWrite = ($urandom() % 2) == 1;
      busWrite(2'd0, byteVal);
      check("R3 dataAvail", dataAvail, 1);
      check("R3 extDataOut", extDataOut, byteVal);
      busRead(2'd2, rd); check("R3 busy status", rd, expStatus(0, 0, 0));
      if (busyWrite) begin
        busWrite(2'd0, ~byteVal);
        check("R6 out unchanged", extDataOut, byteVal);
        busRead(2'd2, rd); check("R6 overrun set", rd, expStatus(0, 0, 1));
        busWrite(2'd2, 8'h00);
        busRead(2'd2, rd); check("R6 no clear w/o bit", rd, expStatus(0, 0, 1));
      end
      idle(int'($urandom() % 5));
      check("R4 held before ack", dataAvail, 1);
      @(negedge clk); dataAccepted = 1'b1;
      idle(2);
      check("R4 still held 2 edges", dataAvail, 1);
      idle(2);
      check("R4 dropped", dataAvail, 0);
      busRead(2'd2, rd); check("R5 not ready while ack", rd, expStatus(0, 0, busyWrite));
      busWrite(2'd0, 8'hEE);
      check("R5 no restart", dataAvail, 0);
      check("R5 out kept", extDataOut, byteVal);
      @(negedge clk); dataAccepted = 1'b0;
      idle(4);
      busRead(2'd2, rd); check("R5 ready again", rd, expStatus(1, 0, 1));
      busWrite(2'd2, 8'h04);
      busRead(2'd2, rd); check("R6 cleared", rd, expStatus(1, 0, 0));
    end

    // R7/R8 random input captures
    busWrite(2'd1, 8'h00);
    check("R2 oe in", extDataOe, 8'h00);
    for (int i = 0; i < 10; i++) begin
      byteVal = 8'($urandom());
      extDataIn = byteVal;
      pulseStrobe();
      extDataIn = ~byteVal;
      busRead(2'd2, rd); check("R7 rx valid", rd, expStatus(1, 1, 0));
      busRead(2'd0, rd); check("R7 rx byte", rd, byteVal);
      busRead(2'd2, rd); check("R8 rx cleared", rd, expStatus(1, 0, 0));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule